// File: doc/BRIEF.md
# Iterative Multi-Cycle Shift Unit

This unit shifts or rotates an 8-bit word by 0 to 7 positions using a single one-bit shift stage. The stage is reused on successive clocks. A caller presents the operand, a 2-bit operation code and a 3-bit amount together with a one-cycle start strobe. The unit captures them and shifts the held word by one bit on each following clock while a copy of the amount, decremented at every step, is still non-zero. The answer always appears a fixed eight clocks after the capture, whatever the amount.

The unit has a fixed latency, so a caller can issue a new operation every eight clocks without watching a ready signal. A start that arrives while an operation is in flight is dropped. A start in the completion cycle is taken, so holding start high gives one operation per eight clocks. The result register keeps its value until the next completion overwrites it.

Top module: `iter_shift_unit`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, done_o is low and result_o is zero.
- R2: Operation code 2'b01 gives an arithmetic right shift: vacated upper bits take a copy of operand bit 7.
- R3: Operation code 2'b00 gives a logical left shift with zeros entering at bit 0.
- R4: Operation code 2'b10 gives a logical right shift with zeros entering at bit 7.
- R5: Operation code 2'b11 gives a right rotate: bits leaving bit 0 re-enter at bit 7.
- R6: An amount of zero returns the operand unchanged, for every operation code.
- R7: If start is accepted at clock edge N, done_o is high for exactly one cycle, after edge N+8, and result_o carries the answer in that same cycle.
- R8: A start is accepted only when the unit is idle, or at the edge that completes the current operation. A start at any other edge has no effect on any later result or done pulse.
- R9: result_o changes only in a cycle where done_o is high. Between completions it holds the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin an operation with the present operand fields |
| op_i | input | 2 | Operation code: 00 left, 01 arithmetic right, 10 logical right, 11 rotate right |
| amt_i | input | 3 | Number of bit positions, 0 to 7 |
| data_i | input | 8 | Operand word |
| result_o | output | 8 | Last completed result, held between completions |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bound checker checks on every cycle that done_o is a single-cycle pulse. Using its own count of accepted starts, it checks that the pulse lands exactly eight edges after acceptance, and that result_o never moves outside a done cycle. The checker does not see the values being shifted. The fill rules of each operation code, the zero-amount pass-through, and the claim that a dropped start leaves no trace in later results are shown only by the bench's reference model. That model replays directed and pseudo-random traffic, including start held high and starts fired mid-operation, and compares the outputs on every clock.

// File: rtl/iter_shift_pkg.sv
package iter_shift_pkg;

    // Operation codes seen on op_i
    typedef enum logic [1:0] {
        OP_SHL = 2'b00,
        OP_SAR = 2'b01,
        OP_SHR = 2'b10,
        OP_ROR = 2'b11
    } shift_op_e;

endpackage

// File: rtl/iter_shift_step.sv
// One-bit shift stage: combinational, applied once per clock by the unit.
module iter_shift_step
    import iter_shift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  shift_op_e          op_i,
    input  logic [WIDTH-1:0]   din_i,
    output logic [WIDTH-1:0]   dout_o
);

    logic to_left;
    logic top_fill;

    always_comb begin
        to_left = (op_i == OP_SHL);
        unique case (op_i)
            OP_SAR:  top_fill = din_i[WIDTH-1];
            OP_ROR:  top_fill = din_i[0];
            default: top_fill = 1'b0;
        endcase
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic from_low;
        logic from_high;
        if (b == 0) begin : g_lsb
            assign from_low = 1'b0;
        end else begin : g_lo
            assign from_low = din_i[b-1];
        end
        if (b == WIDTH-1) begin : g_msb
            assign from_high = top_fill;
        end else begin : g_hi
            assign from_high = din_i[b+1];
        end
        assign dout_o[b] = to_left ? from_low : from_high;
    end

endmodule

// File: rtl/iter_shift_ctrl.sv
// Sequencer: fixed-length busy window plus a decrementing amount copy.
module iter_shift_ctrl #(
    parameter int LAT   = 8,
    parameter int AMT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic             accept_o,
    output logic             step_o,
    output logic             finish_o
);

    localparam int PH_W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(LAT - 1);

    typedef struct packed {
        logic             busy;
        logic [PH_W-1:0]  phase;
        logic [AMT_W-1:0] left;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        finish_o = st_q.busy && (st_q.phase == PH_LAST);
        accept_o = start_i && (!st_q.busy || finish_o);
        step_o   = st_q.busy && (st_q.left != '0);

        st_d = st_q;
        if (st_q.busy) begin
            st_d.phase = st_q.phase + 1'b1;
            if (step_o) begin
                st_d.left = st_q.left - 1'b1;
            end
            if (finish_o) begin
                st_d.busy  = 1'b0;
                st_d.phase = '0;
            end
        end
        if (accept_o) begin
            st_d.busy  = 1'b1;
            st_d.phase = '0;
            st_d.left  = amt_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/iter_shift_unit.sv
module iter_shift_unit
    import iter_shift_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int AMT_W = $clog2(WIDTH),
    parameter int LAT   = WIDTH
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);

    typedef struct packed {
        logic [WIDTH-1:0] work;
        shift_op_e        op;
        logic [WIDTH-1:0] result;
        logic             done;
    } dp_t;

    dp_t dp_d, dp_q;

    logic             accept;
    logic             step;
    logic             finish;
    logic [WIDTH-1:0] stepped;

    iter_shift_ctrl #(
        .LAT   (LAT),
        .AMT_W (AMT_W)
    ) i_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .amt_i    (amt_i),
        .accept_o (accept),
        .step_o   (step),
        .finish_o (finish)
    );

    iter_shift_step #(
        .WIDTH (WIDTH)
    ) i_step (
        .op_i   (dp_q.op),
        .din_i  (dp_q.work),
        .dout_o (stepped)
    );

    always_comb begin
        dp_d      = dp_q;
        dp_d.done = finish;
        if (step) begin
            dp_d.work = stepped;
        end
        if (finish) begin
            dp_d.result = dp_q.work;
        end
        if (accept) begin
            dp_d.work = data_i;
            dp_d.op   = shift_op_e'(op_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign result_o = dp_q.result;
    assign done_o   = dp_q.done;

endmodule

// File: rtl/iter_shift_unit_chk.sv
module iter_shift_unit_chk #(
    parameter int WIDTH = 8,
    parameter int AMT_W = 3,
    parameter int LAT   = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             start_i,
    input logic [WIDTH-1:0] result_o,
    input logic             done_o
);

    localparam int CNT_W = $clog2(LAT + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LAT);

    // Independent count of edges since an accepted start (0 = idle)
    logic [CNT_W-1:0] since_q;
    logic             taken;

    assign taken = start_i && ((since_q == '0) || (since_q == CNT_END));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            since_q <= '0;
        end else if (taken) begin
            since_q <= CNT_W'(1);
        end else if (since_q == CNT_END) begin
            since_q <= '0;
        end else if (since_q != '0) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        rst_i |=> (!done_o && result_o == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R7
    done_on_time_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (since_q == CNT_END) |=> done_o);

    // R8
    no_stray_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (since_q != CNT_END) |=> !done_o);

    // R9
    result_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !done_o |-> $stable(result_o));

endmodule

bind iter_shift_unit iter_shift_unit_chk #(
    .WIDTH (WIDTH),
    .AMT_W (AMT_W),
    .LAT   (LAT)
) i_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (start_i),
    .result_o (result_o),
    .done_o   (done_o)
);

// File: tb/test_iter_shift_unit.sv
`timescale 1ns/1ps
module test_iter_shift_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic [2:0] amt = 3'd0;
    logic [7:0] data = 8'h00;
    logic [7:0] result;
    logic       done;

    int n_checks = 0;
    int n_fail   = 0;
    bit ended    = 1'b0;
    bit checking = 1'b0;

    always #2 clk = ~clk;

    iter_shift_unit i_iter_shift_unit (
        .clk_i    (clk),
        .rst_i    (rst),
        .start_i  (start),
        .op_i     (op),
        .amt_i    (amt),
        .data_i   (data),
        .result_o (result),
        .done_o   (done)
    );

    function automatic logic [7:0] ref_calc(logic [7:0] d, logic [1:0] o, int n);
        logic [15:0] both;
        case (o)
            2'b00:   return d << n;
            2'b01:   return 8'($signed(d) >>> n);
            2'b10:   return d >> n;
            default: begin
                both = {d, d} >> n;
                return both[7:0];
            end
        endcase
    endfunction

    function automatic string op_tag(logic [1:0] o, int n);
        if (n == 0) return "R6";
        case (o)
            2'b00:   return "R3";
            2'b01:   return "R2";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Behavioural reference: integer edge count and a queue of pending finishes
    int         cyc = 0;
    int         due_q[$];
    logic [7:0] val_q[$];
    string      tag_q[$];
    bit         m_exp_done = 1'b0;
    logic [7:0] m_exp_res = 8'h00;
    string      m_res_tag = "R1";

    always @(posedge clk) begin
        if (rst) begin
            cyc        = 0;
            due_q.delete();
            val_q.delete();
            tag_q.delete();
            m_exp_done = 1'b0;
            m_exp_res  = 8'h00;
            m_res_tag  = "R1";
        end else begin
            cyc++;
            m_exp_done = 1'b0;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                m_exp_done = 1'b1;
                m_exp_res  = val_q[0];
                m_res_tag  = tag_q[0];
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end
            // R8: accept only when nothing is pending, or at its finishing edge
            if (start && due_q.size() == 0) begin
                due_q.push_back(cyc + 8);
                val_q.push_back(ref_calc(data, op, int'(amt)));
                tag_q.push_back(op_tag(op, int'(amt)));
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            check(done == m_exp_done, "R7/R8 done", int'(done), int'(m_exp_done));
            if (m_exp_done)
                check(result == m_exp_res, m_res_tag, int'(result), int'(m_exp_res));
            else
                check(result == m_exp_res, "R9 hold", int'(result), int'(m_exp_res));
        end
    end

    task automatic issue(logic [7:0] d, logic [1:0] o, logic [2:0] n);
        @(negedge clk);
        data = d; op = o; amt = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(result == 8'h00, "R1 result", int'(result), 0);
        rst = 1'b0;
        checking = 1'b1;
        @(negedge clk);

        // R2: sign copy, both sign values
        issue(8'b1101_0111, 2'b01, 3'd2);
        issue(8'b0101_0111, 2'b01, 3'd7);
        issue(8'h80, 2'b01, 3'd7);
        // R3
        issue(8'hFF, 2'b00, 3'd3);
        issue(8'h81, 2'b00, 3'd7);
        // R4
        issue(8'hF0, 2'b10, 3'd4);
        issue(8'hFF, 2'b10, 3'd1);
        // R5
        issue(8'h81, 2'b11, 3'd1);
        issue(8'hC3, 2'b11, 3'd7);
        // R6: zero amount on each code
        for (int o = 0; o < 4; o++) issue(8'h9B, 2'(o), 3'd0);

        // R8: stray starts while busy with other fields
        @(negedge clk);
        data = 8'h96; op = 2'b11; amt = 3'd3; start = 1'b1;
        @(negedge clk);
        data = 8'h01; op = 2'b00; amt = 3'd7;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        start = 1'b1; data = 8'hEE;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);

        // R7/R8: start held high, new fields every cycle
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            data  = lfsr;
            op    = lfsr[1:0];
            amt   = lfsr[4:2];
            start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (10) @(negedge clk);

        // Pseudo-random isolated operations with gaps
        for (int k = 0; k < 120; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            issue(lfsr ^ 8'h5A, lfsr[7:6], lfsr[2:0]);
            if (lfsr[3]) @(negedge clk);
        end

        // R1: reset mid-operation clears outputs
        @(negedge clk);
        data = 8'h77; op = 2'b00; amt = 3'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        checking = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 1'b0 && result == 8'h00, "R1 reset again", int'(result), 0);
        rst = 1'b0;
        checking = 1'b1;
        repeat (12) @(negedge clk);
        finish_run();
    end

endmodule